// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Tracker

This block models the timing side of a small banked DRAM. For every request that enters, it decides whether the target row is already held in that bank's row buffer. It then assigns a service time and keeps the bank occupied for that many cycles. Each bank remembers at most one open row. Reaching the open row is quick. Reaching any other row reloads the buffer and costs more. A change of transfer direction on the shared bus between one accepted request and the next adds a fixed stall.

Banks work independently. While one bank counts down its service time, requests to the others are still accepted. A request aimed at a busy bank is not taken: the requester keeps `req_valid` high with the same fields until `req_accept` rises. For each bank, the block also keeps saturating counts of hits and misses. One bank at a time can be read out or cleared.

Top module: `rbt_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every bit of `bank_ready` is 1, `rsp_valid` is 0, and both counters of every bank read 0.
- R2: After reset no bank has an open row, so the first accepted request to each bank is reported as a miss.
- R3: An accepted request whose row equals the open row of its bank is a hit. It reports `rsp_hit`=1 and `rsp_cycles`=HIT_CYC, plus the turnaround stall when R5 applies.
- R4: An accepted request to any other row is a miss. It reports `rsp_hit`=0 and `rsp_cycles`=MISS_CYC, plus any turnaround stall. Its row becomes the bank's open row.
- R5: When an accepted request's direction (`req_write`: 1 = write, 0 = read) differs from the direction of the previously accepted request to any bank, TURN_CYC is added to its service cycles. The first request after reset pays no stall.
- R6: Each accepted request produces exactly one response (`rsp_valid`=1) in the cycle right after acceptance. In all other cycles `rsp_valid` is 0.
- R7: After a bank accepts a request, its `bank_ready` bit is 0 for exactly `rsp_cycles` cycles, starting the next cycle, and then returns to 1.
- R8: `req_accept` is 1 exactly when `req_valid` is 1 and the ready bit of bank `req_bank` is 1. A request that is not accepted changes no open row, no counter and no direction state.
- R9: A busy bank does not hold back the other banks. Their ready bits and acceptance follow only their own state.
- R10: Each bank counts accepted hits and accepted misses in separate counters. The counters stop at the all-ones value of CNT_W bits. They are read combinationally on `cnt_hits`/`cnt_misses` for the bank given by `cnt_sel`.
- R11: `cnt_clear`=1 zeroes both counters of bank `cnt_sel` at the next edge, without touching the other banks. If the same bank accepts a request in that cycle, the clear wins and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until accepted |
| req_bank | input | log2(NUM_BANKS) | Target bank index |
| req_row | input | ROW_W | Target row index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_accept | output | 1 | Request taken this cycle |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_hit | output | 1 | 1 = row-buffer hit, 0 = miss |
| rsp_cycles | output | clog2(MISS_CYC+TURN_CYC+1) | Assigned service cycles |
| bank_ready | output | NUM_BANKS | One ready bit per bank |
| cnt_sel | input | log2(NUM_BANKS) | Bank whose counters are read or cleared |
| cnt_hits | output | CNT_W | Hit count of bank `cnt_sel` |
| cnt_misses | output | CNT_W | Miss count of bank `cnt_sel` |
| cnt_clear | input | 1 | Clear both counters of bank `cnt_sel` |

## Verification
Two cases are hardest to reach from the ports. One is a clear that lands in the same cycle as an acceptance on the same bank. The other is a counter that actually reaches saturation. Random traffic seldom lines these up, so the stimulus hammers one bank with repeated same-row requests until its hit counter stops at the maximum (the bench narrows CNT_W to 4 for this). After that run it issues a clear. Random requests are held until accepted, so they keep colliding with busy banks. A short row pool keeps hits frequent, and mixed read/write traffic triggers turnaround stalls.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // Service time of one request: base cost by row-buffer outcome plus
    // the bus direction-change stall when one applies.
    function automatic int unsigned svc_cycles(
        input logic        is_hit,
        input logic        turn,
        input int unsigned hit_c,
        input int unsigned miss_c,
        input int unsigned turn_c
    );
        int unsigned base;
        base = is_hit ? hit_c : miss_c;
        return turn ? base + turn_c : base;
    endfunction

endpackage

// File: rtl/rbt_turn.sv
module rbt_turn
    import rbt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  dir_e dir_in,
    output logic penalty
);
    logic have_q;
    dir_e last_q;

    assign penalty = have_q && (dir_in != last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            last_q <= DIR_RD;
        end else if (take) begin
            have_q <= 1'b1;
            last_q <= dir_in;
        end
    end

    // R5
    same_dir_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        take ##1 (take && dir_in == $past(dir_in)) |-> !penalty);

endmodule

// File: rtl/rbt_bank.sv
module rbt_bank #(
    parameter int ROW_W = 12,
    parameter int LAT_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [ROW_W-1:0] row,
    input  logic [LAT_W-1:0] lat,
    input  logic             clr,
    output logic             hit,
    output logic             ready,
    output logic [CNT_W-1:0] hits,
    output logic [CNT_W-1:0] misses
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
    } open_t;

    open_t            open_q;
    logic [LAT_W-1:0] busy_q;
    logic [CNT_W-1:0] hit_q;
    logic [CNT_W-1:0] miss_q;

    assign hit    = open_q.vld && (open_q.row == row);
    assign ready  = (busy_q == '0);
    assign hits   = hit_q;
    assign misses = miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= '0;
            busy_q <= '0;
        end else if (take) begin
            open_q.vld <= 1'b1;
            open_q.row <= row;
            busy_q     <= lat;
        end else if (busy_q != '0) begin
            busy_q <= busy_q - LAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hit_q  <= '0;
            miss_q <= '0;
        end else if (take) begin
            if (hit) begin
                if (hit_q != CNT_MAX) hit_q <= hit_q + CNT_W'(1);
            end else begin
                if (miss_q != CNT_MAX) miss_q <= miss_q + CNT_W'(1);
            end
        end
    end

    // R8
    take_only_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> ready);

    // R7
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !ready);

    // R7
    idle_stays_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ready && !take |=> ready);

    // R11
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hits == '0) && (misses == '0));

    // R10
    count_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !clr && $past(!rst) |=> (hits >= $past(hits)) && (misses >= $past(misses)));

endmodule

// File: rtl/rbt_tracker.sv
module rbt_tracker
    import rbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int HIT_CYC   = 3,
    parameter int MISS_CYC  = 9,
    parameter int TURN_CYC  = 2,
    parameter int CNT_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int LAT_W    = $clog2(MISS_CYC + TURN_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic                 req_write,
    output logic                 req_accept,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [LAT_W-1:0]     rsp_cycles,
    output logic [NUM_BANKS-1:0] bank_ready,
    input  logic [BANK_W-1:0]    cnt_sel,
    output logic [CNT_W-1:0]     cnt_hits,
    output logic [CNT_W-1:0]     cnt_misses,
    input  logic                 cnt_clear
);
    logic [NUM_BANKS-1:0] take_vec;
    logic [NUM_BANKS-1:0] clr_vec;
    logic [NUM_BANKS-1:0] hit_vec;
    logic [CNT_W-1:0]     hits_arr   [NUM_BANKS];
    logic [CNT_W-1:0]     misses_arr [NUM_BANKS];
    logic                 sel_hit;
    logic                 turn_pen;
    logic [LAT_W-1:0]     lat;

    assign req_accept = req_valid && bank_ready[req_bank];
    assign sel_hit    = hit_vec[req_bank];
    assign lat        = LAT_W'(svc_cycles(sel_hit, turn_pen, HIT_CYC, MISS_CYC, TURN_CYC));
    assign cnt_hits   = hits_arr[cnt_sel];
    assign cnt_misses = misses_arr[cnt_sel];

    rbt_turn u_turn (
        .clk     (clk),
        .rst     (rst),
        .take    (req_accept),
        .dir_in  (dir_e'(req_write)),
        .penalty (turn_pen)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign take_vec[b] = req_accept && (req_bank == BANK_W'(b));
        assign clr_vec[b]  = cnt_clear && (cnt_sel == BANK_W'(b));

        rbt_bank #(
            .ROW_W (ROW_W),
            .LAT_W (LAT_W),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .take   (take_vec[b]),
            .row    (req_row),
            .lat    (lat),
            .clr    (clr_vec[b]),
            .hit    (hit_vec[b]),
            .ready  (bank_ready[b]),
            .hits   (hits_arr[b]),
            .misses (misses_arr[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_cycles <= '0;
        end else begin
            rsp_valid <= req_accept;
            if (req_accept) begin
                rsp_hit    <= sel_hit;
                rsp_cycles <= lat;
            end
        end
    end

    initial begin
        param_order_chk: assert (HIT_CYC > 0 && MISS_CYC > HIT_CYC && NUM_BANKS == (1 << BANK_W));
    end

    // R6
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        req_accept |=> rsp_valid);

    // R6
    no_rsp_without_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !req_accept |=> !rsp_valid);

    // R3
    hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |->
            (rsp_cycles == LAT_W'(HIT_CYC)) || (rsp_cycles == LAT_W'(HIT_CYC + TURN_CYC)));

    // R4
    miss_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |->
            (rsp_cycles == LAT_W'(MISS_CYC)) || (rsp_cycles == LAT_W'(MISS_CYC + TURN_CYC)));

    // R8
    busy_bank_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !bank_ready[req_bank] |-> !req_accept);

endmodule

// File: tb/rbt_tracker_tb.sv
`timescale 1ns/1ps
module rbt_tracker_tb;
    localparam int NB = 4;
    localparam int BW = 2;
    localparam int RW = 4;
    localparam int H  = 3;
    localparam int M  = 9;
    localparam int T  = 2;
    localparam int CW = 4;
    localparam int LW = $clog2(M + T + 1);
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [BW-1:0] req_bank;
    logic [RW-1:0] req_row;
    logic          req_write;
    logic          req_accept;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [LW-1:0] rsp_cycles;
    logic [NB-1:0] bank_ready;
    logic [BW-1:0] cnt_sel;
    logic [CW-1:0] cnt_hits;
    logic [CW-1:0] cnt_misses;
    logic          cnt_clear;

    always #5 clk = ~clk;

    rbt_tracker #(
        .NUM_BANKS(NB), .ROW_W(RW), .HIT_CYC(H), .MISS_CYC(M),
        .TURN_CYC(T), .CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_write(req_write), .req_accept(req_accept),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cycles(rsp_cycles),
        .bank_ready(bank_ready), .cnt_sel(cnt_sel), .cnt_hits(cnt_hits),
        .cnt_misses(cnt_misses), .cnt_clear(cnt_clear)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int m_busy [NB];
    bit m_vld  [NB];
    int m_row  [NB];
    int m_hits [NB];
    int m_miss [NB];
    bit m_have;
    bit m_last;
    bit e_rv;
    bit e_hit;
    int e_cyc;
    bit e_turn;
    bit e_first;
    bit last_acc;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_cycles(input bit hit, input bit turn);
        return (hit ? H : M) + (turn ? T : 0);
    endfunction

    function automatic int sat_inc(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    // One clock: drive at negedge, check, then advance the model at posedge.
    task automatic cycle(input bit v, input int bank, input int row, input bit wr,
                         input int sel, input bit clr);
        bit acc;
        bit hit;
        bit turn;
        int cyc;
        @(negedge clk);
        req_valid = v;
        req_bank  = BW'(bank);
        req_row   = RW'(row);
        req_write = wr;
        cnt_sel   = BW'(sel);
        cnt_clear = clr;
        // response for the request accepted one edge ago
        check(rsp_valid == e_rv, "R6 rsp_valid", int'(rsp_valid), int'(e_rv));
        if (e_rv) begin
            if (e_first) check(rsp_hit == e_hit, "R2 first access miss", int'(rsp_hit), int'(e_hit));
            else if (e_hit) check(rsp_hit == e_hit, "R3 hit flag", int'(rsp_hit), int'(e_hit));
            else check(rsp_hit == e_hit, "R4 miss flag", int'(rsp_hit), int'(e_hit));
            if (e_turn) check(int'(rsp_cycles) == e_cyc, "R5 turnaround cycles", int'(rsp_cycles), e_cyc);
            else if (e_hit) check(int'(rsp_cycles) == e_cyc, "R3 hit cycles", int'(rsp_cycles), e_cyc);
            else check(int'(rsp_cycles) == e_cyc, "R4 miss cycles", int'(rsp_cycles), e_cyc);
        end
        #1;
        for (int b = 0; b < NB; b++)
            check(bank_ready[b] == (m_busy[b] == 0), "R7 R9 bank_ready",
                  int'(bank_ready[b]), int'(m_busy[b] == 0));
        acc = v && (m_busy[bank] == 0);
        check(req_accept == acc, "R8 accept", int'(req_accept), int'(acc));
        check(int'(cnt_hits) == m_hits[sel], "R10 R11 hit count", int'(cnt_hits), m_hits[sel]);
        check(int'(cnt_misses) == m_miss[sel], "R10 R11 miss count", int'(cnt_misses), m_miss[sel]);
        hit  = m_vld[bank] && (m_row[bank] == row);
        turn = m_have && (m_last != wr);
        cyc  = exp_cycles(hit, turn);
        @(posedge clk);
        for (int b = 0; b < NB; b++) begin
            if (acc && b == bank) m_busy[b] = cyc;
            else if (m_busy[b] > 0) m_busy[b]--;
        end
        if (clr) begin
            m_hits[sel] = 0;
            m_miss[sel] = 0;
        end
        e_rv = acc;
        if (acc) begin
            e_first = !m_vld[bank];
            e_hit   = hit;
            e_turn  = turn;
            e_cyc   = cyc;
            if (!(clr && sel == bank)) begin
                if (hit) m_hits[bank] = sat_inc(m_hits[bank]);
                else     m_miss[bank] = sat_inc(m_miss[bank]);
            end
            m_vld[bank] = 1'b1;
            m_row[bank] = row;
            m_have = 1'b1;
            m_last = wr;
        end
        last_acc = acc;
    endtask

    task automatic send(input int bank, input int row, input bit wr);
        do cycle(1'b1, bank, row, wr, bank, 1'b0); while (!last_acc);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual 0 expected 1 (run ended)");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int p_bank;
        int p_row;
        bit p_wr;
        bit p_v;
        void'($urandom(32'd4242));
        for (int b = 0; b < NB; b++) begin
            m_busy[b] = 0; m_vld[b] = 0; m_row[b] = 0; m_hits[b] = 0; m_miss[b] = 0;
        end
        m_have = 0; m_last = 0; e_rv = 0; e_hit = 0; e_cyc = 0; e_turn = 0;
        e_first = 0; last_acc = 0;
        rst = 1'b1; req_valid = 0; req_bank = '0; req_row = '0; req_write = 0;
        cnt_sel = '0; cnt_clear = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state visible on every bank
        check(bank_ready == '1, "R1 ready after reset", int'(bank_ready), (1 << NB) - 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        for (int b = 0; b < NB; b++) cycle(1'b0, 0, 0, 1'b0, b, 1'b0);

        // directed: first miss, hit while stalled, turnaround, parallel bank
        send(0, 5, 1'b0);      // R2 miss, no stall on first request
        send(0, 5, 1'b0);      // R3 hit after waiting out bank 0
        send(1, 5, 1'b1);      // R5 direction change
        send(0, 7, 1'b1);      // R4 different row
        send(0, 7, 1'b0);      // R3 hit plus R5 stall
        send(1, 2, 1'b1);      // R9 bank 1 while bank 0 is busy
        // R10 saturation on bank 2
        for (int i = 0; i < CMAX + 4; i++) send(2, 3, 1'b0);
        cycle(1'b0, 0, 0, 1'b0, 2, 1'b0);
        // R11 clear bank 2, then observe it and a neighbour
        cycle(1'b0, 0, 0, 1'b0, 2, 1'b1);
        cycle(1'b0, 0, 0, 1'b0, 2, 1'b0);
        cycle(1'b0, 0, 0, 1'b0, 0, 1'b0);
        // R11 clear colliding with an accept on the same bank
        while (m_busy[3] != 0) cycle(1'b0, 0, 0, 1'b0, 3, 1'b0);
        cycle(1'b1, 3, 1, 1'b0, 3, 1'b1);
        cycle(1'b0, 0, 0, 1'b0, 3, 1'b0);

        // random traffic, each request held until it is accepted
        p_v = 0; p_bank = 0; p_row = 0; p_wr = 0;
        for (int i = 0; i < 4000; i++) begin
            if (!p_v || last_acc) begin
                p_v    = ($urandom_range(0, 9) < 7);
                p_bank = $urandom_range(0, NB - 1);
                p_row  = $urandom_range(0, 3);
                p_wr   = ($urandom_range(0, 9) < 3);
            end
            cycle(p_v, p_bank, p_row, p_wr, $urandom_range(0, NB - 1),
                  ($urandom_range(0, 99) < 3));
        end
        cycle(1'b0, 0, 0, 1'b0, 0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule